// File: doc/BRIEF.md
# Disk Channel Interrupt Status Unit

This unit collects the two interrupt causes of a single-channel disk interface, a device interrupt and a memory-side bus error, into a small pending word. A single interrupt line is raised whenever a pending cause is also enabled. Software acknowledges causes by writing ones to the pending word. Enables are managed through a pair of registers, one that sets enable bits and one that clears them. When a bus error is first flagged, the failing memory address is latched so that software can read it back.

There is also a hardware acknowledge. The surrounding logic reports each read of the attached drive's status byte, together with the value returned. If that byte shows the drive is not busy, both pending causes are dropped as a side effect of the read. Register access uses a word index, a write strobe and write data. Read data is returned combinationally for the selected index. Any address decoding above the word index happens outside this unit.

Top module: `dsk_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, the pending bits, enable bits and captured address are all zero, and `irq_o` is low.
- R2: A high `dev_irq_i` sets pending bit 0, and a high `mem_err_i` sets pending bit 1, at the next clock edge. Reading word index 3 returns the pending bits in bits 1:0 and zeros above them.
- R3: A write to index 3 clears each pending bit whose write-data bit is 1. Write-data bits that are 0 leave the pending bits unchanged.
- R4: A write to index 5 sets the enable bits whose data bit is 1. A write to index 7 clears the enable bits whose data bit is 1. Reading index 5 or index 7 returns the enable bits in bits 1:0.
- R5: `irq_o` is high exactly when some pending bit and its matching enable bit are both 1, and it follows the registered state with no extra delay.
- R6: A source event in the same cycle as a clear of its bit wins, so the bit remains set. This holds whether the clear comes from a write to index 3 or from an automatic acknowledge.
- R7: When pending bit 1 goes from 0 to 1, the 64-bit `mem_err_addr_i` is captured. Index 0 returns bits 31:0 of the captured address and index 1 returns bits 63:32. Further errors while bit 1 is set do not change it. After bit 1 is cleared, the value is kept until the next capture.
- R8: A drive-status read (`dev_stat_rd_i` high) clears both pending bits when the status byte has any bit of mask 0x51 set and bit 7 clear.
- R9: A drive-status read leaves the pending bits unchanged when status bit 7 (busy) is set or when no bit of mask 0x51 is set.
- R10: Indices 2, 4 and 6 read as zero, and writes to them change neither pending nor enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_irq_i | input | 1 | Device interrupt event |
| mem_err_i | input | 1 | Memory/bus error event |
| mem_err_addr_i | input | 64 | Address associated with the memory error |
| dev_stat_rd_i | input | 1 | Strobe: the drive status byte is being read |
| dev_stat_i | input | 8 | Status byte returned by that read |
| reg_sel_i | input | 3 | Register word index |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the selected index |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest behaviour to reach is the automatic acknowledge. It depends on an 8-bit status value, and only one part of that value range clears the pending bits. The stimulus sets both pending bits before every one of the 256 status codes, performs a status read, and compares the pending word against the mask-and-busy rule computed in the bench. Two other cases need a specific alignment of events in one cycle: an event arriving on the same edge as its clear, and a second error arriving while the first address is still held. The stimulus drives both of these at the same edge.

// File: rtl/dsk_irq_pkg.sv
// Shared constants for the disk interrupt status unit.
// Assumes two interrupt causes and a 32-bit register data path.
package dsk_irq_pkg;
    localparam int N_SRC      = 2;
    localparam int SRC_DEV    = 0;
    localparam int SRC_MEM    = 1;
    localparam int SEL_W      = 3;
    localparam logic [SEL_W-1:0] IDX_ADDR_LO = 3'd0;
    localparam logic [SEL_W-1:0] IDX_ADDR_HI = 3'd1;
    localparam logic [SEL_W-1:0] IDX_PEND    = 3'd3;
    localparam logic [SEL_W-1:0] IDX_EN_SET  = 3'd5;
    localparam logic [SEL_W-1:0] IDX_EN_CLR  = 3'd7;
    localparam logic [7:0] STAT_READY_MASK = 8'h51;
    localparam int STAT_BUSY_BIT = 7;
    typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/dsk_irq_flag.sv
// One sticky flag bit: set_i forces it to 1, clr_i forces it to 0, and
// set wins over clear. Assumes a synchronous active-low reset.
module dsk_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold, set or clear the flag; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end
endmodule

// File: rtl/dsk_irq_errcap.sv
// Error address holder: latches addr_i when capture_i is high and keeps it
// otherwise. The caller decides when a capture is a first occurrence.
module dsk_irq_errcap #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    // Load the address on a capture and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_o <= '0;
        else if (capture_i)
            addr_o <= addr_i;
    end
endmodule

// File: rtl/dsk_irq_regread.sv
// Read multiplexer: returns the captured address halves, the pending word
// or the enable word for the selected index, and zero for any other index.
module dsk_irq_regread
    import dsk_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [SEL_W-1:0]    sel_i,
    input  src_vec_t            pend_i,
    input  src_vec_t            en_i,
    input  logic [2*DATA_W-1:0] addr_i,
    output logic [DATA_W-1:0]   rdata_o
);
    // Select the word that belongs to the requested index.
    always_comb begin
        rdata_o = '0;
        case (sel_i)
            IDX_ADDR_LO: rdata_o = addr_i[DATA_W-1:0];
            IDX_ADDR_HI: rdata_o = addr_i[2*DATA_W-1:DATA_W];
            IDX_PEND:    rdata_o[N_SRC-1:0] = pend_i;
            IDX_EN_SET,
            IDX_EN_CLR:  rdata_o[N_SRC-1:0] = en_i;
            default:     rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dsk_irq_unit.sv
// Interrupt status unit for a single-channel disk interface.
// Latches a device interrupt and a memory error into a pending word, gates
// them with an enable word onto irq_o, holds the first error address, and
// drops pending causes on a write-one-to-clear or on a not-busy status read.
// Assumes the event inputs are synchronous to clk.
module dsk_irq_unit
    import dsk_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dev_irq_i,
    input  logic                mem_err_i,
    input  logic [2*DATA_W-1:0] mem_err_addr_i,
    input  logic                dev_stat_rd_i,
    input  logic [7:0]          dev_stat_i,
    input  logic [SEL_W-1:0]    reg_sel_i,
    input  logic                reg_wr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                irq_o
);
    localparam int ADDR_W = 2 * DATA_W;

    src_vec_t          evt;
    src_vec_t          pend_q;
    src_vec_t          en_q;
    src_vec_t          pend_clr;
    src_vec_t          en_set;
    src_vec_t          en_clr;
    logic              auto_ack;
    logic              err_capture;
    logic [ADDR_W-1:0] err_addr_q;

    // Gather the event sources in pending-bit order.
    always_comb begin
        evt          = '0;
        evt[SRC_DEV] = dev_irq_i;
        evt[SRC_MEM] = mem_err_i;
    end

    // A status read that shows a ready drive acknowledges every cause.
    always_comb begin
        auto_ack = dev_stat_rd_i
                 && ((dev_stat_i & STAT_READY_MASK) != 8'h00)
                 && !dev_stat_i[STAT_BUSY_BIT];
    end

    // Decode register writes into per-bit clear and enable controls.
    always_comb begin
        pend_clr = {N_SRC{auto_ack}};
        en_set   = '0;
        en_clr   = '0;
        if (reg_wr_i) begin
            case (reg_sel_i)
                IDX_PEND:   pend_clr = pend_clr | reg_wdata_i[N_SRC-1:0];
                IDX_EN_SET: en_set   = reg_wdata_i[N_SRC-1:0];
                IDX_EN_CLR: en_clr   = reg_wdata_i[N_SRC-1:0];
                default:    ;
            endcase
        end
    end

    // One pending flag and one enable flag per source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        dsk_irq_flag u_pend (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt[g]),
            .clr_i (pend_clr[g]),
            .q_o   (pend_q[g])
        );
        dsk_irq_flag u_en (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (en_set[g]),
            .clr_i (en_clr[g]),
            .q_o   (en_q[g])
        );
    end

    // Capture the error address only when the error bit is currently clear.
    always_comb begin
        err_capture = mem_err_i && !pend_q[SRC_MEM];
    end

    dsk_irq_errcap #(.ADDR_W(ADDR_W)) u_errcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (err_capture),
        .addr_i    (mem_err_addr_i),
        .addr_o    (err_addr_q)
    );

    dsk_irq_regread #(.DATA_W(DATA_W)) u_rd (
        .sel_i   (reg_sel_i),
        .pend_i  (pend_q),
        .en_i    (en_q),
        .addr_i  (err_addr_q),
        .rdata_o (reg_rdata_o)
    );

    // Raise the line when any enabled cause is pending.
    always_comb begin
        irq_o = |(pend_q & en_q);
    end
endmodule

// File: rtl/dsk_irq_chk.sv
// Property checker for dsk_irq_unit, attached with bind below.
module dsk_irq_chk
    import dsk_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dev_irq_i,
    input logic                mem_err_i,
    input logic                dev_stat_rd_i,
    input logic [7:0]          dev_stat_i,
    input logic [SEL_W-1:0]    reg_sel_i,
    input logic                reg_wr_i,
    input logic [DATA_W-1:0]   reg_wdata_i,
    input logic                irq_o,
    input src_vec_t            pend_q,
    input src_vec_t            en_q,
    input logic [2*DATA_W-1:0] err_addr_q
);
    // R6: an event always leaves its bit set on the next cycle.
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dev_irq_i) |-> pend_q[SRC_DEV]);

    // R3: a write of 1 to bit 0 with no concurrent event clears it.
    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(reg_wr_i && reg_sel_i == IDX_PEND && reg_wdata_i[0] && !dev_irq_i)
        |-> !pend_q[SRC_DEV]);

    // R8: a ready status read with no new events empties the pending word.
    a_r8_auto_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dev_stat_rd_i && ((dev_stat_i & STAT_READY_MASK) != 8'h00)
                              && !dev_stat_i[7] && !dev_irq_i && !mem_err_i)
        |-> pend_q == '0);

    // R9: a busy status read without a register write keeps the pending word.
    a_r9_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dev_stat_rd_i && dev_stat_i[7] && !reg_wr_i)
        |-> (pend_q & $past(pend_q)) == $past(pend_q));

    // R5: no line without an enable.
    a_r5_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        en_q == '0 |-> !irq_o);

    // R7: the address is stable while the error bit stays set.
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(pend_q[SRC_MEM]) |-> $stable(err_addr_q));
endmodule

bind dsk_irq_unit dsk_irq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dev_irq_i     (dev_irq_i),
    .mem_err_i     (mem_err_i),
    .dev_stat_rd_i (dev_stat_rd_i),
    .dev_stat_i    (dev_stat_i),
    .reg_sel_i     (reg_sel_i),
    .reg_wr_i      (reg_wr_i),
    .reg_wdata_i   (reg_wdata_i),
    .irq_o         (irq_o),
    .pend_q        (pend_q),
    .en_q          (en_q),
    .err_addr_q    (err_addr_q)
);

// File: tb/dsk_irq_unit_tb.sv
`timescale 1ns/1ps
module dsk_irq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_irq_i = 1'b0;
    logic        mem_err_i = 1'b0;
    logic [63:0] mem_err_addr_i = '0;
    logic        dev_stat_rd_i = 1'b0;
    logic [7:0]  dev_stat_i = '0;
    logic [2:0]  reg_sel_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dsk_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .dev_irq_i(dev_irq_i), .mem_err_i(mem_err_i),
        .mem_err_addr_i(mem_err_addr_i), .dev_stat_rd_i(dev_stat_rd_i),
        .dev_stat_i(dev_stat_i), .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        reg_sel_i = idx;
        #0.5;
        v = reg_rdata_o;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        reg_sel_i = idx; reg_wdata_i = d; reg_wr_i = 1'b1;
        step();
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic raise(input logic [1:0] p, input logic [63:0] a);
        dev_irq_i = p[0]; mem_err_i = p[1]; mem_err_addr_i = a;
        step();
        dev_irq_i = 1'b0; mem_err_i = 1'b0;
    endtask

    task automatic stat_read(input logic [7:0] s);
        dev_stat_rd_i = 1'b1; dev_stat_i = s;
        step();
        dev_stat_rd_i = 1'b0; dev_stat_i = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq_o}, 32'h0);

        // R2: each source sets its own bit
        raise(2'b01, 64'h0);
        rd(3, v); chk("R2 device bit", v, 32'h1);
        raise(2'b10, 64'h1234_5678_9ABC_DEF0);
        rd(3, v); chk("R2 both bits", v, 32'h3);
        rd(0, v); chk("R7 addr low", v, 32'h9ABC_DEF0);
        rd(1, v); chk("R7 addr high", v, 32'h1234_5678);

        // R3 and R10: write-one-to-clear sweep, unused indices inert
        for (int p = 0; p < 4; p++) begin
            for (int w = 0; w < 4; w++) begin
                wr(3, 32'h3);
                raise(2'(p), 64'(p));
                wr(3, 32'(w) | 32'hFFFF_FFF0);
                rd(3, v); chk("R3 w1c", v, 32'(p & ~w & 3));
                wr(2, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF); wr(6, 32'hFFFF_FFFF);
                rd(3, v); chk("R10 pending unchanged", v, 32'(p & ~w & 3));
                rd(5, v); chk("R10 enable unchanged", v, 32'h0);
                rd(2, v); chk("R10 idx2 zero", v, 32'h0);
                rd(4, v); chk("R10 idx4 zero", v, 32'h0);
                rd(6, v); chk("R10 idx6 zero", v, 32'h0);
            end
        end

        // R4 and R5: enable set/clear and gated line
        for (int e = 0; e < 4; e++) begin
            for (int p = 0; p < 4; p++) begin
                wr(7, 32'h3);
                wr(3, 32'h3);
                wr(5, 32'(e));
                raise(2'(p), 64'h0);
                rd(5, v); chk("R4 enable via set idx", v, 32'(e));
                rd(7, v); chk("R4 enable via clr idx", v, 32'(e));
                chk("R5 irq", {31'b0, irq_o}, {31'b0, ((p & e) != 0)});
                for (int c = 0; c < 4; c++) begin
                    wr(5, 32'h3);
                    wr(7, 32'(c));
                    rd(5, v); chk("R4 enable clear", v, 32'(3 & ~c));
                    chk("R5 irq after clear", {31'b0, irq_o}, {31'b0, ((p & ~c & 3) != 0)});
                end
            end
        end
        wr(7, 32'h3);

        // R6: event on the same edge as a clear
        wr(3, 32'h3);
        raise(2'b11, 64'h0);
        dev_irq_i = 1'b1; reg_sel_i = 3; reg_wdata_i = 32'h3; reg_wr_i = 1'b1;
        step();
        dev_irq_i = 1'b0; reg_wr_i = 1'b0;
        rd(3, v); chk("R6 event beats w1c", v, 32'h1);
        raise(2'b10, 64'h0);
        mem_err_i = 1'b1; dev_stat_rd_i = 1'b1; dev_stat_i = 8'h50;
        step();
        mem_err_i = 1'b0; dev_stat_rd_i = 1'b0;
        rd(3, v); chk("R6 event beats auto ack", v, 32'h2);

        // R7: capture on first error only, held after clear
        wr(3, 32'h3);
        raise(2'b10, 64'hAAAA_0001_BBBB_0002);
        raise(2'b10, 64'hCCCC_0003_DDDD_0004);
        rd(0, v); chk("R7 held low", v, 32'hBBBB_0002);
        rd(1, v); chk("R7 held high", v, 32'hAAAA_0001);
        wr(3, 32'h2);
        rd(0, v); chk("R7 kept after clear", v, 32'hBBBB_0002);
        raise(2'b10, 64'h1111_2222_3333_4444);
        rd(1, v); chk("R7 recapture high", v, 32'h1111_2222);
        rd(0, v); chk("R7 recapture low", v, 32'h3333_4444);

        // R8 and R9: every status code against the ready/busy rule
        for (int s = 0; s < 256; s++) begin
            raise(2'b11, 64'h0);
            stat_read(8'(s));
            rd(3, v);
            if (((s & 8'h51) != 0) && ((s & 8'h80) == 0))
                chk("R8 ready read clears", v, 32'h0);
            else
                chk("R9 busy or not ready keeps", v, 32'h3);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule